// File: doc/BRIEF.md
# Shared-Adder Halfband 2x Interpolator

This block doubles the sample rate of a signed audio-style stream with a 47-tap halfband FIR. Every input sample arrives with a one-cycle strobe on a fast processing clock that runs 256 times faster than the input rate. For each accepted input, the block emits two output samples, spaced evenly 128 fast cycles apart. The first output is the filtered branch. The second output is the centre-tap branch, which is simply an older input sample passed through.

The filtered branch needs no hardware multiplier. The twelve distinct nonzero side coefficients are fixed in canonic-signed-digit form. The block adds each symmetric pair of stored samples first. It then accumulates one shifted copy of that pair sum per nonzero digit, and all of this work passes through a single adder. The last 24 input samples are kept in a small circular storage array with one access per cycle, instead of a register chain. After accumulation, the block restores the passband gain of 2, rounds the result and saturates it to the sample width.

Top module: `halfband_interp2x`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `out_data` is 0 until the first accepted input strobe.
- R2: Call the rising edge that captures an accepted strobe edge E. `out_valid` is high for exactly one cycle after edge E+127, and again after edge E+255. No other pulse occurs before the next accepted strobe.
- R3: The second output for an accepted sample x[n] equals x[n-11] bit for bit.
- R4: The first output is the rounded, saturated value of 2*S/2^15. S is the sum over p=0..11 of c_p*(x[n-11+p]+x[n-12-p]). The coefficients c_0..c_11 are 10418, -3400, 1900, -1200, 800, -540, 360, -230, 140, -80, 42, -18.
- R5: Rounding adds 2^13 to S and then shifts arithmetically right by 14, so exact halves round toward plus infinity. A lone +512 sample meeting c_9 gives -2, and a lone -512 sample gives +3.
- R6: Results above 2^23-1 give 2^23-1, and results below -2^23 give -2^23 (DW=24).
- R7: Reset empties the delay line, so samples written before reset never influence later outputs.
- R8: A constant input held for at least 24 samples produces that same constant on both output phases.
- R9: A strobe is ignored when it arrives before CYC=256 cycles have passed since the last accepted strobe. It is not stored, it adds no output pulse, and the output stream is unchanged.
- R10: Strobes spaced exactly 256 cycles apart are all accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processing clock (256x input rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle strobe marking a new input sample |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking an output sample |
| out_data | output | DW | Signed output sample, held between strobes |

## Verification
The bench drives single impulses so that each coefficient shows up on its own at the output. A wrong CSD digit or a swapped pair address therefore shows up as a wrong value at a known output index. It places ±512 impulses on the -80 tap, where the sum lands exactly on a rounding half: a design that truncates or rounds away from zero returns -3 or +2 in place of -2 and +3. Sign-matched full-scale patterns push the sum past both rails, and a design without saturation wraps to the opposite sign. Further tests inject early strobes, and a reset in the middle of a stream. A design that accepted the early strobe would shift the history and add pulses. A design that kept stale memory across reset would produce nonzero outputs from zero input.

// File: rtl/hbi_pkg.sv
`timescale 1ns/1ps
package hbi_pkg;
  localparam int CW         = 16;              // coefficient word
  localparam int TAPS       = 47;
  localparam int NPAIR      = (TAPS + 1) / 4;  // symmetric pairs in the filtered branch
  localparam int CENTER_DLY = NPAIR - 1;       // delay of the pass-through branch
  localparam int FRAC       = CW - 2;          // Q15 coefficients with gain of 2
  localparam int MAXDIG     = CW / 2 + 1;      // most nonzero CSD digits per word

  typedef enum logic [2:0] {OP_IDLE, OP_LOAD, OP_PAIR, OP_MAC, OP_CENTER} dp_op_e;

  typedef struct packed {
    logic       nz;
    logic       neg;
    logic       last;
    logic [3:0] sh;
  } csd_dig_t;

  // Coefficient by pair index; pair p sits at centre distance 2p+1.
  function automatic int pair_coef(int p);
    case (p)
      0:  return 10418;
      1:  return -3400;
      2:  return 1900;
      3:  return -1200;
      4:  return 800;
      5:  return -540;
      6:  return 360;
      7:  return -230;
      8:  return 140;
      9:  return -80;
      10: return 42;
      11: return -18;
      default: return 0;
    endcase
  endfunction

  function automatic int csd_count(int c);
    int v;
    int n;
    int d;
    v = c;
    n = 0;
    for (int i = 0; i <= CW; i++) begin
      if ((v & 1) != 0) begin
        d = ((v & 3) == 1) ? 1 : -1;
        n = n + 1;
        v = (v - d) >>> 1;
      end else begin
        v = v >>> 1;
      end
    end
    return n;
  endfunction

  // idx-th nonzero digit of the CSD form of c, least significant first.
  function automatic csd_dig_t csd_pick(int c, int idx);
    csd_dig_t r;
    int v;
    int n;
    int d;
    int total;
    r = '0;
    v = c;
    n = 0;
    total = csd_count(c);
    for (int i = 0; i <= CW; i++) begin
      if ((v & 1) != 0) begin
        d = ((v & 3) == 1) ? 1 : -1;
        if (n == idx) begin
          r.nz   = 1'b1;
          r.neg  = (d < 0);
          r.sh   = 4'(i);
          r.last = (n == total - 1);
        end
        n = n + 1;
        v = (v - d) >>> 1;
      end else begin
        v = v >>> 1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/hbi_csd_table.sv
`timescale 1ns/1ps
module hbi_csd_table
  import hbi_pkg::*;
#(
  parameter int PW = 4,
  parameter int KW = 4
) (
  input  logic [PW-1:0] pair_idx,
  input  logic [KW-1:0] dig_idx,
  output csd_dig_t      dig
);
  localparam int NP = 1 << PW;
  localparam int NK = 1 << KW;

  csd_dig_t tbl [NP][NK];

  for (genvar gp = 0; gp < NP; gp++) begin : g_pair
    for (genvar gk = 0; gk < NK; gk++) begin : g_dig
      if (gp < NPAIR && gk < MAXDIG) begin : g_real
        assign tbl[gp][gk] = csd_pick(pair_coef(gp), gk);
      end else begin : g_pad
        assign tbl[gp][gk] = '0;
      end
    end
  end

  assign dig = tbl[pair_idx][dig_idx];
endmodule

// File: rtl/hbi_delay_mem.sv
`timescale 1ns/1ps
module hbi_delay_mem #(
  parameter int DW    = 24,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // one access per cycle: write or registered read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end else begin
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/hbi_shift_adder.sv
`timescale 1ns/1ps
module hbi_shift_adder
  import hbi_pkg::*;
#(
  parameter int DW    = 24,
  parameter int ACC_W = 46
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  dp_op_e           op,
  input  csd_dig_t         dig,
  input  logic [DW-1:0]    rdata,
  output logic [ACC_W-1:0] acc,
  output logic [DW-1:0]    mid,
  output logic [ACC_W-1:0] add_out
);
  localparam int PSW = DW + 1;

  logic [PSW-1:0]   pair;
  logic [ACC_W-1:0] pair_x, rd_x, opa, opb;
  logic             inv;

  assign pair_x = {{(ACC_W-PSW){pair[PSW-1]}}, pair};
  assign rd_x   = {{(ACC_W-DW){rdata[DW-1]}}, rdata};

  // operand multiplexers in front of the one adder
  assign opa     = (op == OP_MAC) ? acc : pair_x;
  assign opb     = (op == OP_MAC) ? (pair_x << dig.sh) : rd_x;
  assign inv     = (op == OP_MAC) && dig.neg;
  assign add_out = opa + (opb ^ {ACC_W{inv}}) + {{(ACC_W-1){1'b0}}, inv};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair <= '0;
      acc  <= '0;
      mid  <= '0;
    end else begin
      if (start) acc <= '0;
      case (op)
        OP_LOAD:   pair <= {rdata[DW-1], rdata};
        OP_PAIR:   pair <= add_out[PSW-1:0];
        OP_MAC:    acc  <= add_out;
        OP_CENTER: mid  <= rdata;
        default:   ;
      endcase
    end
  end

  // R4: the accumulator keeps a spare sign bit after every digit step
  p_acc_headroom_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MAC) |=> (acc[ACC_W-1] == acc[ACC_W-2]));
endmodule

// File: rtl/hbi_seq.sv
`timescale 1ns/1ps
module hbi_seq
  import hbi_pkg::*;
#(
  parameter int CYC = 256,
  parameter int AW  = 5,
  parameter int PW  = 4,
  parameter int KW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  csd_dig_t      dig,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output dp_op_e        op,
  output logic          start,
  output logic [PW-1:0] pair_idx,
  output logic [KW-1:0] dig_idx,
  output logic          slot_even,
  output logic          slot_odd,
  output logic          accept
);
  localparam int CNTW = $clog2(CYC + 1);
  localparam int HALF = CYC / 2;

  typedef enum logic [2:0] {S_IDLE, S_RDA, S_RDB, S_SUM, S_DIG, S_RDC, S_CAPC} st_e;

  st_e             state;
  logic [CNTW-1:0] cnt;
  logic [AW-1:0]   head;
  logic [PW-1:0]   p;
  logic [KW-1:0]   k;

  assign accept    = in_valid && (cnt == CNTW'(CYC)) && (state == S_IDLE);
  assign start     = accept;
  assign slot_even = (cnt == CNTW'(HALF - 1));
  assign slot_odd  = (cnt == CNTW'(CYC - 1));
  assign pair_idx  = p;
  assign dig_idx   = k;

  always_comb begin
    mem_we   = 1'b0;
    mem_addr = head + AW'(1);
    op       = OP_IDLE;
    case (state)
      S_IDLE: mem_we = accept;
      S_RDA:  mem_addr = head - (AW'(CENTER_DLY) - AW'(p));
      S_RDB: begin
        mem_addr = head - (AW'(NPAIR) + AW'(p));
        op       = OP_LOAD;
      end
      S_SUM:  op = OP_PAIR;
      S_DIG:  op = OP_MAC;
      S_RDC:  mem_addr = head - AW'(CENTER_DLY);
      S_CAPC: op = OP_CENTER;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= CNTW'(CYC);
      head  <= '0;
      p     <= '0;
      k     <= '0;
    end else begin
      if (accept) cnt <= CNTW'(1);
      else if (cnt != CNTW'(CYC)) cnt <= cnt + CNTW'(1);
      case (state)
        S_IDLE: if (accept) begin
          head  <= head + AW'(1);
          p     <= '0;
          state <= S_RDA;
        end
        S_RDA: state <= S_RDB;
        S_RDB: state <= S_SUM;
        S_SUM: begin
          k     <= '0;
          state <= S_DIG;
        end
        S_DIG: begin
          if (dig.last) begin
            if (p == PW'(NPAIR - 1)) state <= S_RDC;
            else begin
              p     <= p + PW'(1);
              state <= S_RDA;
            end
          end else begin
            k <= k + KW'(1);
          end
        end
        S_RDC:   state <= S_CAPC;
        S_CAPC:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: the digit schedule has finished before the first output slot
  p_fir_done_by_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_even |-> (state == S_IDLE));
  // R9: an early strobe leaves the write pointer untouched
  p_busy_strobe_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !accept) |=> $stable(head));
  // R4: every sequenced digit step uses a real nonzero digit
  p_digit_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DIG) |-> dig.nz);
  // R10: a strobe that lands on a completed slot period starts a new sample
  p_full_rate_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state == S_RDA) && (cnt == CNTW'(1)));
endmodule

// File: rtl/halfband_interp2x.sv
`timescale 1ns/1ps
module halfband_interp2x
  import hbi_pkg::*;
#(
  parameter int DW  = 24,
  parameter int CYC = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int DEPTH = 1 << $clog2(2 * NPAIR);
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = $clog2(NPAIR);
  localparam int KW    = $clog2(MAXDIG);
  localparam int ACC_W = DW + 1 + CW + PW + 1;

  logic             mem_we, start, slot_even, slot_odd, accept;
  logic [AW-1:0]    mem_addr;
  logic [DW-1:0]    rdata, mid;
  logic [PW-1:0]    pair_idx;
  logic [KW-1:0]    dig_idx;
  logic [ACC_W-1:0] acc, add_out;
  logic [DW-1:0]    even_result;
  dp_op_e           op;
  csd_dig_t         dig;

  // gain of 2, round half up, clamp to DW bits
  function automatic logic [DW-1:0] round_sat(input logic [ACC_W-1:0] a);
    logic [ACC_W-1:0] biased;
    logic [ACC_W-1:0] shifted;
    biased  = a + (ACC_W'(1) << (FRAC - 1));
    shifted = ACC_W'($signed(biased) >>> FRAC);
    if ((&shifted[ACC_W-1:DW-1]) || !(|shifted[ACC_W-1:DW-1]))
      return shifted[DW-1:0];
    else if (shifted[ACC_W-1])
      return {1'b1, {(DW-1){1'b0}}};
    else
      return {1'b0, {(DW-1){1'b1}}};
  endfunction

  hbi_seq #(.CYC(CYC), .AW(AW), .PW(PW), .KW(KW)) u_seq (
    .clk, .rst_n, .in_valid, .dig,
    .mem_we, .mem_addr, .op, .start, .pair_idx, .dig_idx,
    .slot_even, .slot_odd, .accept
  );

  hbi_csd_table #(.PW(PW), .KW(KW)) u_tbl (
    .pair_idx, .dig_idx, .dig
  );

  hbi_delay_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk, .rst_n, .we(mem_we), .addr(mem_addr), .wdata(in_data), .rdata
  );

  hbi_shift_adder #(.DW(DW), .ACC_W(ACC_W)) u_dp (
    .clk, .rst_n, .start, .op, .dig, .rdata, .acc, .mid, .add_out
  );

  assign even_result = round_sat(acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= slot_even || slot_odd;
      if (slot_even)     out_data <= even_result;
      else if (slot_odd) out_data <= mid;
    end
  end

  // R2: each output strobe lasts a single cycle
  p_out_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R1: no output strobe in the cycle after an accepted input
  p_no_pulse_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !out_valid);
endmodule

// File: tb/halfband_interp2x_bench.sv
`timescale 1ns/1ps
module halfband_interp2x_bench;
  localparam int DW  = 24;
  localparam int CYC = 256;
  localparam longint VMAX = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint VMIN = -(64'sd1 <<< (DW - 1));

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int     n_checks = 0;
  int     n_fail   = 0;
  longint hist [24];
  longint last_even, last_odd;
  bit     done = 1'b0;

  always #2.5 clk = ~clk;

  halfband_interp2x #(.DW(DW), .CYC(CYC)) u_halfband_interp2x (
    .clk, .rst_n, .in_valid, .in_data, .out_valid, .out_data
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint tap_coef(int j);
    int d;
    d = (2 * j > 23) ? 2 * j - 23 : 23 - 2 * j;
    case (d)
      1:  return 10418;
      3:  return -3400;
      5:  return 1900;
      7:  return -1200;
      9:  return 800;
      11: return -540;
      13: return 360;
      15: return -230;
      17: return 140;
      19: return -80;
      21: return 42;
      23: return -18;
      default: return 0;
    endcase
  endfunction

  // direct convolution over all 24 stored taps, own rounding form
  function automatic longint model_even();
    longint s;
    s = 0;
    for (int j = 0; j < 24; j++) s += tap_coef(j) * hist[j];
    s = (2 * s + 16384) >>> 15;
    if (s > VMAX) s = VMAX;
    if (s < VMIN) s = VMIN;
    return s;
  endfunction

  function automatic longint sval(input logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic clear_hist();
    for (int j = 0; j < 24; j++) hist[j] = 0;
  endtask

  // drive one sample, check both phases at their exact cycles
  task automatic send(input longint x, input int glitch, input string req);
    longint exp_e, exp_o;
    int pulses;
    for (int j = 23; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = x;
    exp_e = model_even();
    exp_o = hist[11];
    pulses = 0;
    in_valid = 1'b1;
    in_data  = DW'(x);
    for (int e = 1; e <= 256; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e == 1) in_valid = 1'b0;
      if (glitch != 0 && e == glitch) begin
        in_valid = 1'b1;
        in_data  = DW'(12345);
      end
      if (glitch != 0 && e == glitch + 1) in_valid = 1'b0;
      if (out_valid) pulses++;
      if (e == 128) begin
        check(out_valid === 1'b1, "R2 even slot", longint'(out_valid), 1);
        last_even = sval(out_data);
        check(last_even == exp_e, req, last_even, exp_e);
      end
      if (e == 256) begin
        check(out_valid === 1'b1, "R2 odd slot", longint'(out_valid), 1);
        last_odd = sval(out_data);
        check(last_odd == exp_o, "R3", last_odd, exp_o);
      end
    end
    check(pulses == 2, "R2,R10 pulse count", pulses, 2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 valid in reset", longint'(out_valid), 0);
    check(out_data === '0, "R1 data in reset", sval(out_data), 0);
    rst_n = 1'b1;
    clear_hist();
    repeat (5) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R1 idle after reset", longint'(out_valid), 0);
    end
  endtask

  task automatic t_impulse();
    do_reset();
    send(1000, 0, "R4 impulse");
    for (int i = 0; i < 25; i++) send(0, 0, "R4 impulse tail");
  endtask

  task automatic t_dc();
    do_reset();
    for (int i = 0; i < 30; i++) send(3000, 0, "R8 dc");
    check(last_even == 3000, "R8 dc even", last_even, 3000);
    check(last_odd == 3000, "R8 dc odd", last_odd, 3000);
  endtask

  task automatic t_round();
    do_reset();
    send(512, 0, "R5");
    send(0, 0, "R5");
    send(0, 0, "R5");
    check(last_even == -2, "R5 half up positive impulse", last_even, -2);
    do_reset();
    send(-512, 0, "R5");
    send(0, 0, "R5");
    send(0, 0, "R5");
    check(last_even == 3, "R5 half up negative impulse", last_even, 3);
  endtask

  task automatic t_sat(input bit invert);
    bit pos;
    int j;
    do_reset();
    for (int k = 0; k < 24; k++) begin
      j = 23 - k;
      pos = (j <= 11) ? ((11 - j) % 2 == 0) : ((j - 12) % 2 == 0);
      if (invert) pos = !pos;
      send(pos ? VMAX : VMIN, 0, "R6 stream");
    end
    if (invert) check(last_even == VMIN, "R6 low rail", last_even, VMIN);
    else        check(last_even == VMAX, "R6 high rail", last_even, VMAX);
  endtask

  task automatic t_mixed();
    int unsigned s;
    longint v;
    do_reset();
    s = 32'h1234_5678;
    for (int i = 0; i < 40; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      v = longint'($signed(s[31:8])) >>> 1;
      send(v, 0, "R4 mixed");
    end
  endtask

  task automatic t_glitch();
    do_reset();
    for (int i = 0; i < 12; i++) send(longint'(i * 7000 - 40000), 100 + i, "R9 early strobe");
    check(last_odd == -40000 + 7000 * 0, "R9 history intact", last_odd, -40000);
  endtask

  task automatic t_reset_history();
    do_reset();
    for (int i = 0; i < 8; i++) send(2000000, 0, "R4 prefill");
    do_reset();
    for (int i = 0; i < 12; i++) begin
      send(0, 0, "R7 cleared history");
      check(last_even == 0 && last_odd == 0, "R7 zero after reset", last_even | last_odd, 0);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    clear_hist();
    last_even = 0;
    last_odd  = 0;
    t_impulse();
    t_dc();
    t_round();
    t_sat(1'b0);
    t_sat(1'b1);
    t_mixed();
    t_glitch();
    t_reset_history();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      report();
    end
  end
endmodule